// File: doc/BRIEF.md
# Cross-Clock Mailbox Bypass

This block passes single 36-bit words between two independently clocked ports without going through the bulk FIFO storage. There is one mailbox for each direction. The A-to-B mailbox is written from port A and read at port B. The B-to-A mailbox works the other way round. Each receiving port sees an active-low mail flag that goes low once a fresh word is waiting and returns high once that word has been taken.

Each port samples four control inputs on its own rising clock edge: a select, a direction bit, an enable and a mailbox-select bit. When mailbox-select is high the access targets the mailbox. When it is low the access becomes a strobe towards the FIFO write or read path, which sits outside this block. Write and read events cross the clock boundary as toggle handshakes. The sending side refuses a new word until the receiver has consumed the previous one. Each direction has its own active-low reset.

Top module: `mbx_bypass`

## Requirements
- R1: A port performs a mailbox write on its rising clock edge when select=1, dir=1 (write), enable=1 and mbx=1, and the mailbox is empty. The word is stored and the receiving port's mail flag goes low.
- R2: A port performs a mailbox read on its rising clock edge when select=1, dir=0 (read), enable=1 and mbx=1, and its mail flag is low. The stored word appears on that port's data output after that edge, and the flag returns high on that same edge.
- R3: With select=1, enable=1 and mbx=0, the port raises its FIFO-write strobe for dir=1 or its FIFO-read strobe for dir=0, combinationally from the inputs. Neither mailbox nor flag is affected.
- R4: A mailbox write while the previous word is still unread is ignored. The stored word and the flag keep their values.
- R5: A mailbox read while the port's mail flag is high leaves the data output and the flag unchanged.
- R6: The two mailboxes are independent. Traffic in one direction never changes the other direction's flag or data.
- R7: Asserting a direction's reset clears that mailbox's word, the receiving data output (to 0) and the flag (to high) at once. The other direction keeps its state.
- R8: With select=0 or enable=0, no access of any kind takes place, and both FIFO strobes stay low.
- R9: After a mailbox write, the receiving flag goes low within 4 receiving-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_ab_n | input | 1 | Active-low reset of the A-to-B mailbox |
| rst_ba_n | input | 1 | Active-low reset of the B-to-A mailbox |
| a_sel | input | 1 | Port A select |
| a_dir | input | 1 | Port A direction, 1 = write, 0 = read |
| a_en | input | 1 | Port A enable |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | 36 | Port A write data |
| a_dout | output | 36 | Word last read from the B-to-A mailbox |
| a_mail_n | output | 1 | Low while the B-to-A mailbox holds unread mail |
| a_fifo_wr | output | 1 | Port A FIFO write strobe |
| a_fifo_rd | output | 1 | Port A FIFO read strobe |
| b_sel | input | 1 | Port B select |
| b_dir | input | 1 | Port B direction, 1 = write, 0 = read |
| b_en | input | 1 | Port B enable |
| b_mbx | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B write data |
| b_dout | output | 36 | Word last read from the A-to-B mailbox |
| b_mail_n | output | 1 | Low while the A-to-B mailbox holds unread mail |
| b_fifo_wr | output | 1 | Port B FIFO write strobe |
| b_fifo_rd | output | 1 | Port B FIFO read strobe |

## Verification
A toggle bit that drifts out of step between the two domains shows up as a mail flag stuck low or stuck high. That error is visible within a few receiving-clock cycles of the next access. A corrupted held word appears on the data output at the very next valid read. A sender that loses track of the busy state overwrites unread mail, and the following read then returns the newer word instead of the original. The bench waits for every handshake to settle after each access and then compares both flags and both data outputs against a model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W = 36;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_FIFO_WR,
    OP_FIFO_RD,
    OP_MB_WR,
    OP_MB_RD
  } port_op_e;

  function automatic port_op_e decode_op(input logic sel, input logic dir,
                                         input logic en, input logic mbx);
    port_op_e op;
    op = OP_IDLE;
    if (sel && en) begin
      if (mbx) op = dir ? OP_MB_WR : OP_MB_RD;
      else     op = dir ? OP_FIFO_WR : OP_FIFO_RD;
    end
    return op;
  endfunction
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_bit_sync.sv
module mbx_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
(
  input  logic sel,
  input  logic dir,
  input  logic en,
  input  logic mbx,
  output logic mb_wr,
  output logic mb_rd,
  output logic fifo_wr,
  output logic fifo_rd
);
  port_op_e op;

  always_comb begin
    op      = decode_op(sel, dir, en, mbx);
    mb_wr   = (op == OP_MB_WR);
    mb_rd   = (op == OP_MB_RD);
    fifo_wr = (op == OP_FIFO_WR);
    fifo_rd = (op == OP_FIFO_RD);
  end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned WIDTH       = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             tx_clk,
  input  logic             tx_rst_n,
  input  logic             tx_wr,
  input  logic [WIDTH-1:0] tx_data,
  input  logic             rx_clk,
  input  logic             rx_rst_n,
  input  logic             rx_rd,
  output logic [WIDTH-1:0] rx_data,
  output logic             rx_mail_n
);
  // sending domain
  logic [WIDTH-1:0] word_q, word_d;
  logic             wtgl_q, wtgl_d;
  logic             ack_s;
  logic             busy, accept;

  // receiving domain
  logic             wtgl_s;
  logic             rtgl_q, rtgl_d;
  logic [WIDTH-1:0] dout_q, dout_d;
  logic             full, take;

  mbx_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(tx_clk), .rst_n(tx_rst_n), .d(rtgl_q), .q(ack_s));

  mbx_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(rx_clk), .rst_n(rx_rst_n), .d(wtgl_q), .q(wtgl_s));

  always_comb begin
    busy   = wtgl_q ^ ack_s;
    accept = tx_wr && !busy;
    word_d = word_q;
    wtgl_d = wtgl_q;
    if (accept) begin
      word_d = tx_data;
      wtgl_d = ~wtgl_q;
    end
  end

  always_ff @(posedge tx_clk or negedge tx_rst_n) begin
    if (!tx_rst_n) begin
      word_q <= '0;
      wtgl_q <= 1'b0;
    end else if (accept) begin
      word_q <= word_d;
      wtgl_q <= wtgl_d;
    end
  end

  always_comb begin
    full   = wtgl_s ^ rtgl_q;
    take   = rx_rd && full;
    rtgl_d = rtgl_q;
    dout_d = dout_q;
    if (take) begin
      rtgl_d = ~rtgl_q;
      dout_d = word_q;   // held stable while the sender is busy
    end
  end

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      rtgl_q <= 1'b0;
      dout_q <= '0;
    end else if (take) begin
      rtgl_q <= rtgl_d;
      dout_q <= dout_d;
    end
  end

  assign rx_data   = dout_q;
  assign rx_mail_n = ~full;
endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass
  import mbx_pkg::*;
#(
  parameter int unsigned WIDTH       = WORD_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst_ab_n,
  input  logic             rst_ba_n,
  input  logic             a_sel,
  input  logic             a_dir,
  input  logic             a_en,
  input  logic             a_mbx,
  input  logic [WIDTH-1:0] a_din,
  output logic [WIDTH-1:0] a_dout,
  output logic             a_mail_n,
  output logic             a_fifo_wr,
  output logic             a_fifo_rd,
  input  logic             b_sel,
  input  logic             b_dir,
  input  logic             b_en,
  input  logic             b_mbx,
  input  logic [WIDTH-1:0] b_din,
  output logic [WIDTH-1:0] b_dout,
  output logic             b_mail_n,
  output logic             b_fifo_wr,
  output logic             b_fifo_rd
);
  localparam int unsigned NPORT = 2;

  // index 0 = port A, 1 = port B; channel d is written by port d
  logic [NPORT-1:0]            clk, arst_n, sel, dir, en, mbx;
  logic [NPORT-1:0]            mb_wr, mb_rd, fifo_wr, fifo_rd, mail_n;
  logic [NPORT-1:0][WIDTH-1:0] din, dout;

  assign clk    = {clk_b, clk_a};
  assign arst_n = {rst_ba_n, rst_ab_n};
  assign sel    = {b_sel, a_sel};
  assign dir    = {b_dir, a_dir};
  assign en     = {b_en, a_en};
  assign mbx    = {b_mbx, a_mbx};
  assign din    = {b_din, a_din};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mbx_port_decode u_dec (
      .sel(sel[p]), .dir(dir[p]), .en(en[p]), .mbx(mbx[p]),
      .mb_wr(mb_wr[p]), .mb_rd(mb_rd[p]),
      .fifo_wr(fifo_wr[p]), .fifo_rd(fifo_rd[p]));
  end

  for (genvar d = 0; d < NPORT; d++) begin : g_chan
    localparam int unsigned RX = NPORT - 1 - d;
    logic tx_rst_n, rx_rst_n;

    mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_tx_rst (
      .clk(clk[d]), .arst_n(arst_n[d]), .rst_n(tx_rst_n));
    mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_rx_rst (
      .clk(clk[RX]), .arst_n(arst_n[d]), .rst_n(rx_rst_n));

    mbx_channel #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chan (
      .tx_clk(clk[d]), .tx_rst_n(tx_rst_n), .tx_wr(mb_wr[d]),
      .tx_data(din[d]),
      .rx_clk(clk[RX]), .rx_rst_n(rx_rst_n), .rx_rd(mb_rd[RX]),
      .rx_data(dout[RX]), .rx_mail_n(mail_n[RX]));
  end

  assign a_dout    = dout[0];
  assign b_dout    = dout[1];
  assign a_mail_n  = mail_n[0];
  assign b_mail_n  = mail_n[1];
  assign a_fifo_wr = fifo_wr[0];
  assign a_fifo_rd = fifo_rd[0];
  assign b_fifo_wr = fifo_wr[1];
  assign b_fifo_rd = fifo_rd[1];
endmodule

// File: rtl/mbx_bypass_chk.sv
module mbx_bypass_chk #(
  parameter int unsigned WIDTH = 36
) (
  input logic             clk_a,
  input logic             clk_b,
  input logic             rst_ab_n,
  input logic             rst_ba_n,
  input logic             a_sel,
  input logic             a_dir,
  input logic             a_en,
  input logic             a_mbx,
  input logic [WIDTH-1:0] a_dout,
  input logic             a_mail_n,
  input logic             a_fifo_wr,
  input logic             a_fifo_rd,
  input logic             b_sel,
  input logic             b_dir,
  input logic             b_en,
  input logic             b_mbx,
  input logic [WIDTH-1:0] b_dout,
  input logic             b_mail_n,
  input logic             b_fifo_wr,
  input logic             b_fifo_rd
);
  logic a_rd, b_rd;
  assign a_rd = a_sel && !a_dir && a_en && a_mbx;
  assign b_rd = b_sel && !b_dir && b_en && b_mbx;

  // R2: a read that finds mail releases the flag on the next edge
  a_r2_flag_release_b: assert property (@(posedge clk_b) disable iff (!rst_ab_n)
    (b_rd && !b_mail_n) |=> b_mail_n);
  a_r2_flag_release_a: assert property (@(posedge clk_a) disable iff (!rst_ba_n)
    (a_rd && !a_mail_n) |=> a_mail_n);

  // R5: the data output only moves on a mailbox read
  a_r5_dout_hold_b: assert property (@(posedge clk_b) disable iff (!rst_ab_n)
    !b_rd |=> $stable(b_dout));
  a_r5_dout_hold_a: assert property (@(posedge clk_a) disable iff (!rst_ba_n)
    !a_rd |=> $stable(a_dout));

  // R7: a held reset keeps the receiving side empty and cleared
  a_r7_reset_empty_b: assert property (@(posedge clk_b)
    !rst_ab_n |-> (b_mail_n && b_dout == '0));
  a_r7_reset_empty_a: assert property (@(posedge clk_a)
    !rst_ba_n |-> (a_mail_n && a_dout == '0));

  // R3 / R8: FIFO strobes follow the access type
  a_r3_fifo_route_a: assert property (@(posedge clk_a) disable iff (!rst_ab_n)
    (a_sel && a_en && !a_mbx) |-> (a_fifo_wr != a_fifo_rd));
  a_r8_idle_quiet_b: assert property (@(posedge clk_b) disable iff (!rst_ba_n)
    !(b_sel && b_en) |-> !(b_fifo_wr || b_fifo_rd));
endmodule

bind mbx_bypass mbx_bypass_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/mbx_bypass_tb_top.sv
`timescale 1ns/1ps
module mbx_bypass_tb_top;
  localparam int W = 36;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_ab_n, rst_ba_n;
  logic a_sel, a_dir, a_en, a_mbx, b_sel, b_dir, b_en, b_mbx;
  logic [W-1:0] a_din, b_din, a_dout, b_dout;
  logic a_mail_n, b_mail_n, a_fifo_wr, a_fifo_rd, b_fifo_wr, b_fifo_rd;

  always #4   clk_a = ~clk_a;   // 125 MHz
  always #5.5 clk_b = ~clk_b;   // unrelated receiving clock

  mbx_bypass dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // model, index 0 = A-to-B, 1 = B-to-A
  logic [W-1:0] m_word [2];
  bit           m_full [2];
  logic [W-1:0] m_dout [2];

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_fwr(bit s, bit d, bit e, bit m);
    return s && e && !m && d;
  endfunction
  function automatic bit exp_frd(bit s, bit d, bit e, bit m);
    return s && e && !m && !d;
  endfunction

  task automatic settle();
    repeat (8) @(negedge clk_b);
    @(negedge clk_a);
  endtask

  task automatic check_state(input string req);
    chk(b_mail_n == !m_full[0], {req, " b_mail_n"}, W'(b_mail_n), W'(!m_full[0]));
    chk(a_mail_n == !m_full[1], {req, " a_mail_n"}, W'(a_mail_n), W'(!m_full[1]));
    chk(b_dout == m_dout[0], {req, " b_dout"}, b_dout, m_dout[0]);
    chk(a_dout == m_dout[1], {req, " a_dout"}, a_dout, m_dout[1]);
  endtask

  // one access on port p, then settle and compare
  task automatic op(input int p, input bit s, input bit d, input bit e,
                    input bit m, input logic [W-1:0] data, input string req);
    if (p == 0) begin
      @(negedge clk_a);
      a_sel = s; a_dir = d; a_en = e; a_mbx = m; a_din = data;
      #1;
      chk(a_fifo_wr == exp_fwr(s, d, e, m), {req, " a_fifo_wr"}, W'(a_fifo_wr), W'(exp_fwr(s, d, e, m)));
      chk(a_fifo_rd == exp_frd(s, d, e, m), {req, " a_fifo_rd"}, W'(a_fifo_rd), W'(exp_frd(s, d, e, m)));
      @(negedge clk_a);
      a_sel = 0; a_en = 0; a_mbx = 0;
    end else begin
      @(negedge clk_b);
      b_sel = s; b_dir = d; b_en = e; b_mbx = m; b_din = data;
      #1;
      chk(b_fifo_wr == exp_fwr(s, d, e, m), {req, " b_fifo_wr"}, W'(b_fifo_wr), W'(exp_fwr(s, d, e, m)));
      chk(b_fifo_rd == exp_frd(s, d, e, m), {req, " b_fifo_rd"}, W'(b_fifo_rd), W'(exp_frd(s, d, e, m)));
      @(negedge clk_b);
      b_sel = 0; b_en = 0; b_mbx = 0;
    end
    if (s && e && m) begin
      if (d) begin
        if (!m_full[p]) begin m_word[p] = data; m_full[p] = 1; end
      end else if (m_full[1-p]) begin
        m_dout[1-p] = m_word[1-p]; m_full[1-p] = 0;
      end
    end
    settle();
    check_state(req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    {a_sel, a_dir, a_en, a_mbx, b_sel, b_dir, b_en, b_mbx} = '0;
    a_din = '0; b_din = '0;
    rst_ab_n = 0; rst_ba_n = 0;
    for (int i = 0; i < 2; i++) begin m_word[i] = '0; m_full[i] = 0; m_dout[i] = '0; end
    repeat (3) @(negedge clk_b);
    check_state("R7 reset");
    rst_ab_n = 1; rst_ba_n = 1;
    settle();

    // R1 / R2 basic transfers both ways
    op(0, 1, 1, 1, 1, 36'h9_8765_4321, "R1 write A");
    op(1, 1, 0, 1, 1, '0, "R2 read B");
    op(1, 1, 1, 1, 1, 36'hF_0F0F_0F0F, "R1 write B");
    op(0, 1, 0, 1, 1, '0, "R2 read A");
    // R5 read with no mail
    op(1, 1, 0, 1, 1, '0, "R5 empty read B");
    // R4 overwrite attempt
    op(0, 1, 1, 1, 1, 36'h1_1111_1111, "R4 first write");
    op(0, 1, 1, 1, 1, 36'h2_2222_2222, "R4 ignored write");
    op(1, 1, 0, 1, 1, '0, "R4 read original");
    // R3 FIFO routing, R8 inactive accesses
    op(0, 1, 1, 1, 0, 36'h3_3333_3333, "R3 fifo write A");
    op(1, 1, 0, 1, 0, '0, "R3 fifo read B");
    op(0, 0, 1, 1, 1, 36'h4_4444_4444, "R8 no select");
    op(1, 1, 1, 0, 1, 36'h5_5555_5555, "R8 no enable");
    // R6 one direction full, other used
    op(0, 1, 1, 1, 1, 36'hA_AAAA_AAAA, "R6 fill A-to-B");
    op(1, 1, 1, 1, 1, 36'hB_BBBB_BBBB, "R6 fill B-to-A");
    op(0, 1, 0, 1, 1, '0, "R6 drain B-to-A only");

    // R7 reset of A-to-B while both hold mail
    op(1, 1, 1, 1, 1, 36'hC_CCCC_CCCC, "R7 prefill B-to-A");
    @(negedge clk_b);
    rst_ab_n = 0;
    #1;
    chk(b_mail_n == 1'b1, "R7 flag during reset", W'(b_mail_n), W'(1));
    chk(b_dout == '0, "R7 dout during reset", b_dout, '0);
    chk(a_mail_n == 1'b0, "R7 other direction kept", W'(a_mail_n), W'(0));
    repeat (2) @(negedge clk_a);
    rst_ab_n = 1;
    m_word[0] = '0; m_full[0] = 0; m_dout[0] = '0;
    settle();
    check_state("R7 after reset");
    op(1, 1, 0, 1, 1, '0, "R7 empty after reset");

    // R9 latency
    begin
      int n;
      @(negedge clk_a);
      a_sel = 1; a_dir = 1; a_en = 1; a_mbx = 1; a_din = 36'h7_7777_7777;
      @(negedge clk_a);
      a_sel = 0; a_en = 0; a_mbx = 0;
      n = 0;
      while (b_mail_n && n < 6) begin @(negedge clk_b); n++; end
      chk(n <= 4 && !b_mail_n, "R9 flag latency", W'(n), W'(4));
      m_word[0] = 36'h7_7777_7777; m_full[0] = 1;
      @(negedge clk_b);
      b_sel = 1; b_dir = 0; b_en = 1; b_mbx = 1;
      @(negedge clk_b);
      b_sel = 0; b_en = 0; b_mbx = 0;
      chk(b_mail_n == 1'b1, "R2 flag high next edge", W'(b_mail_n), W'(1));
      chk(b_dout == 36'h7_7777_7777, "R2 word after read", b_dout, 36'h7_7777_7777);
      m_full[0] = 0; m_dout[0] = 36'h7_7777_7777;
      settle();
    end

    // random mix, R6 across both directions
    for (int i = 0; i < 250; i++) begin
      int p;
      logic [W-1:0] dv;
      p = int'($urandom_range(1, 0));
      dv = {$urandom, $urandom};
      op(p, ($urandom_range(7, 0) != 0), $urandom_range(1, 0),
         ($urandom_range(7, 0) != 0), ($urandom_range(3, 0) != 0), dv, "R6 random");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule